// File: doc/BRIEF.md
# Protection Unit Configuration Register File

This block is the configuration store that sits beside a region-based memory protection checker. Software reaches it through a coprocessor-style access encoding made of three fields: a primary register number (0 to 15), a secondary opcode (0 to 7) and a secondary register number (0 to 15). It has one write port and one read port. Each port carries a 32-bit word and raises an undefined-register flag in the same cycle when the encoding is not supported.

The file holds three kinds of state. The first is a pair of read-only identification constants. The second is the control word, whose bit 0 is the global protection enable. The third covers the data and instruction cacheable masks, the write buffer control, the data and instruction access permission words, and eight region descriptors. The stored values drive the checker directly.

Access permissions are held in an extended form with one nibble per region. The file also offers a compact view with two bits per region. A compact write spreads each 2-bit field into the low half of its nibble and clears the upper half. A compact read gathers the low halves back together.

Top module: `prot_cfg_regfile`

## Requirements
- R1: After reset every writable register holds zero, and so do prot_enable, the cacheable, write buffer, permission and region outputs.
- R2: Primary 0 reads 0x41059461 for op2=0 and 0x0F004006 for op2=1. A read with any other op2 is an error. Every write to primary 0 is an error.
- R3: Primary 1 with op2=0 is the control word and can be read and written. Its bit 0 appears on prot_enable after the write's clock edge. Any other op2 is an error.
- R4: Primary 2 with op2=0 is the data cacheable mask and with op2=1 the instruction cacheable mask. Op2 values 2 to 7 are errors.
- R5: Primary 3 is the write buffer control word for every op2 and crm value.
- R6: A write to primary 5 with op2=0 (data) or op2=1 (instruction) takes the compact form. Bits 2i+1:2i of the data, for regions i = 0..7, go to bits 4i+1:4i of the stored permission word. Bits 4i+3:4i+2 become zero, and data bits 31:16 are ignored.
- R7: A read of primary 5 with op2=0 (data) or op2=1 (instruction) returns bits 4i+1:4i of the stored word in bits 2i+1:2i, with bits 31:16 equal to zero.
- R8: Primary 5 with op2=2 (data) or op2=3 (instruction) reads and writes the full extended permission word unchanged. Op2 values 4 to 7 are errors.
- R9: Primary 6 with crm 0 to 7 addresses region descriptor crm, whatever op2 is. A crm of 8 or more is an error.
- R10: Primaries 4 and 7 to 15 (among them primary 9 with crm=1, 11 and 12) are errors on both ports.
- R11: An error flag is raised combinationally in the same cycle as the access. An erroring read returns zero. An erroring write changes no stored state.
- R12: Reads are combinational from the stored values. A valid write becomes visible only after the clock edge on which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| wr_prim | input | 4 | Write primary register number |
| wr_op2 | input | 3 | Write secondary opcode |
| wr_crm | input | 4 | Write secondary register number |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Write addresses an undefined register |
| rd_en | input | 1 | Read request |
| rd_prim | input | 4 | Read primary register number |
| rd_op2 | input | 3 | Read secondary opcode |
| rd_crm | input | 4 | Read secondary register number |
| rd_data | output | 32 | Read data, zero when idle or on error |
| rd_err | output | 1 | Read addresses an undefined register |
| prot_enable | output | 1 | Global protection enable (control bit 0) |
| data_cacheable | output | 32 | Data cacheable mask |
| insn_cacheable | output | 32 | Instruction cacheable mask |
| wbuf_ctrl | output | 32 | Write buffer control word |
| data_perm_ext | output | 32 | Data permissions, one nibble per region |
| insn_perm_ext | output | 32 | Instruction permissions, one nibble per region |
| region_desc | output | 256 | Region descriptors, region n in bits 32n+31:32n |

## Verification
The assertions assume that the encoding fields are known whenever their enable is high, and that reset is applied before the first access. The bench holds every field at a defined value and moves it only at the falling clock edge. It raises at most one enable at a time, except for one deliberate same-cycle case that shows a write is not visible until after its edge. The stateless checks on the write side assume that wr_data stays stable across the edge that commits it, and the bench drives it that way.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  parameter int unsigned CFG_DW      = 32;
  parameter int unsigned CFG_REGIONS = 8;
  parameter int unsigned CFG_NIB     = 4;
  parameter int unsigned CFG_FLD     = 2;
  parameter logic [CFG_DW-1:0] CFG_ID_WORD    = 32'h4105_9461;
  parameter logic [CFG_DW-1:0] CFG_CTYPE_WORD = 32'h0F00_4006;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_CDATA, SEL_CINSN, SEL_WBUF,
    SEL_PD_CMP, SEL_PI_CMP, SEL_PD_EXT, SEL_PI_EXT, SEL_REGION
  } cfg_sel_e;

  // spread compact 2-bit fields into the low half of each nibble
  function automatic logic [CFG_DW-1:0] perm_expand(input logic [CFG_DW-1:0] c);
    logic [CFG_DW-1:0] x;
    x = '0;
    for (int i = 0; i < CFG_REGIONS; i++)
      x[CFG_NIB*i +: CFG_FLD] = c[CFG_FLD*i +: CFG_FLD];
    return x;
  endfunction

  // gather the low half of each nibble back into packed 2-bit fields
  function automatic logic [CFG_DW-1:0] perm_compact(input logic [CFG_DW-1:0] x);
    logic [CFG_DW-1:0] c;
    c = '0;
    for (int i = 0; i < CFG_REGIONS; i++)
      c[CFG_FLD*i +: CFG_FLD] = x[CFG_NIB*i +: CFG_FLD];
    return c;
  endfunction

  // bits a compact write must leave at zero in the extended word
  function automatic logic [CFG_DW-1:0] perm_hi_mask();
    logic [CFG_DW-1:0] m;
    m = '0;
    for (int i = 0; i < CFG_REGIONS; i++)
      m[CFG_NIB*i+CFG_FLD +: (CFG_NIB-CFG_FLD)] = '1;
    return m;
  endfunction
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NREG = CFG_REGIONS
) (
  input  logic [3:0] prim,
  input  logic [2:0] op2,
  input  logic [3:0] crm,
  input  logic       is_write,
  output cfg_sel_e   sel,
  output logic       undef
);
  always_comb begin
    sel = SEL_NONE;
    unique case (prim)
      4'd0: begin
        if (!is_write && op2 == 3'd0)      sel = SEL_ID;
        else if (!is_write && op2 == 3'd1) sel = SEL_CTYPE;
      end
      4'd1: if (op2 == 3'd0) sel = SEL_CTRL;
      4'd2: begin
        if (op2 == 3'd0)      sel = SEL_CDATA;
        else if (op2 == 3'd1) sel = SEL_CINSN;
      end
      4'd3: sel = SEL_WBUF;
      4'd5: begin
        case (op2)
          3'd0:    sel = SEL_PD_CMP;
          3'd1:    sel = SEL_PI_CMP;
          3'd2:    sel = SEL_PD_EXT;
          3'd3:    sel = SEL_PI_EXT;
          default: sel = SEL_NONE;
        endcase
      end
      4'd6: if (int'(crm) < int'(NREG)) sel = SEL_REGION;
      default: sel = SEL_NONE;
    endcase
  end

  assign undef = (sel == SEL_NONE);
endmodule

// File: rtl/cfg_region_bank.sv
module cfg_region_bank
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NREG = CFG_REGIONS,
  parameter int unsigned DW   = CFG_DW,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    wdata,
  output logic [NREG*DW-1:0] regions
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] desc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          desc_q <= '0;
      else if (we && idx == IW'(g))        desc_q <= wdata;
    end
    assign regions[g*DW +: DW] = desc_q;
  end
endmodule

// File: rtl/prot_cfg_regfile.sv
module prot_cfg_regfile
  import prot_cfg_pkg::*;
#(
  parameter int unsigned NREG = CFG_REGIONS,
  parameter int unsigned DW   = CFG_DW,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_prim,
  input  logic [2:0]        wr_op2,
  input  logic [3:0]        wr_crm,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_err,
  input  logic              rd_en,
  input  logic [3:0]        rd_prim,
  input  logic [2:0]        rd_op2,
  input  logic [3:0]        rd_crm,
  output logic [DW-1:0]     rd_data,
  output logic              rd_err,
  output logic              prot_enable,
  output logic [DW-1:0]     data_cacheable,
  output logic [DW-1:0]     insn_cacheable,
  output logic [DW-1:0]     wbuf_ctrl,
  output logic [DW-1:0]     data_perm_ext,
  output logic [DW-1:0]     insn_perm_ext,
  output logic [NREG*DW-1:0] region_desc
);
  localparam logic [DW-1:0] PERM_HI = perm_hi_mask();

  cfg_sel_e wr_sel, rd_sel;
  logic     wr_undef, rd_undef;
  logic     wr_commit;

  cfg_decode #(.NREG(NREG)) u_wdec (
    .prim(wr_prim), .op2(wr_op2), .crm(wr_crm), .is_write(1'b1),
    .sel(wr_sel), .undef(wr_undef));

  cfg_decode #(.NREG(NREG)) u_rdec (
    .prim(rd_prim), .op2(rd_op2), .crm(rd_crm), .is_write(1'b0),
    .sel(rd_sel), .undef(rd_undef));

  assign wr_err    = wr_en && wr_undef;
  assign rd_err    = rd_en && rd_undef;
  assign wr_commit = wr_en && !wr_undef;

  logic [DW-1:0] ctrl_q, cdata_q, cinsn_q, wbuf_q, pd_q, pi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cdata_q <= '0;
      cinsn_q <= '0;
      wbuf_q  <= '0;
      pd_q    <= '0;
      pi_q    <= '0;
    end else if (wr_commit) begin
      case (wr_sel)
        SEL_CTRL:   ctrl_q  <= wr_data;
        SEL_CDATA:  cdata_q <= wr_data;
        SEL_CINSN:  cinsn_q <= wr_data;
        SEL_WBUF:   wbuf_q  <= wr_data;
        SEL_PD_CMP: pd_q    <= perm_expand(wr_data);
        SEL_PI_CMP: pi_q    <= perm_expand(wr_data);
        SEL_PD_EXT: pd_q    <= wr_data;
        SEL_PI_EXT: pi_q    <= wr_data;
        default: ;
      endcase
    end
  end

  logic region_we;
  assign region_we = wr_commit && (wr_sel == SEL_REGION);

  cfg_region_bank #(.NREG(NREG), .DW(DW)) u_regions (
    .clk(clk), .rst_n(rst_n), .we(region_we),
    .idx(wr_crm[IW-1:0]), .wdata(wr_data), .regions(region_desc));

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (rd_sel)
      SEL_ID:     rd_mux = CFG_ID_WORD;
      SEL_CTYPE:  rd_mux = CFG_CTYPE_WORD;
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_CDATA:  rd_mux = cdata_q;
      SEL_CINSN:  rd_mux = cinsn_q;
      SEL_WBUF:   rd_mux = wbuf_q;
      SEL_PD_CMP: rd_mux = perm_compact(pd_q);
      SEL_PI_CMP: rd_mux = perm_compact(pi_q);
      SEL_PD_EXT: rd_mux = pd_q;
      SEL_PI_EXT: rd_mux = pi_q;
      SEL_REGION: rd_mux = region_desc[int'(rd_crm[IW-1:0])*DW +: DW];
      default:    rd_mux = '0;
    endcase
  end

  assign rd_data = (rd_en && !rd_undef) ? rd_mux : '0;

  assign prot_enable    = ctrl_q[0];
  assign data_cacheable = cdata_q;
  assign insn_cacheable = cinsn_q;
  assign wbuf_ctrl      = wbuf_q;
  assign data_perm_ext  = pd_q;
  assign insn_perm_ext  = pi_q;

  // R2: every write to the identification register is refused
  a_r2_id_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prim == 4'd0) |-> wr_err);

  // R2: identification constant on the read port
  a_r2_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_prim == 4'd0 && rd_op2 == 3'd0) |-> (!rd_err && rd_data == CFG_ID_WORD));

  // R3: control bit 0 reaches the checker enable after the write edge
  a_r3_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_prim == 4'd1) |=> (prot_enable == $past(wr_data[0])));

  // R6: compact writes leave the upper half of every nibble clear
  a_r6_compact_clears_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_prim == 4'd5 && wr_op2 == 3'd0) |=> ((data_perm_ext & PERM_HI) == '0));

  // R9: out-of-range region index is undefined
  a_r9_region_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_prim == 4'd6 && wr_crm >= 4'd8) |-> wr_err);

  // R11: an erroring write leaves every stored value untouched
  a_r11_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err) |=> ($stable(ctrl_q) && $stable(cdata_q) && $stable(cinsn_q) &&
                           $stable(wbuf_q) && $stable(pd_q) && $stable(pi_q) &&
                           $stable(region_desc)));

  // R11: an erroring read returns zero
  a_r11_err_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0));
endmodule

// File: tb/prot_cfg_regfile_test.sv
module prot_cfg_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] wr_prim = 0, wr_crm = 0, rd_prim = 0, rd_crm = 0;
  logic [2:0] wr_op2 = 0, rd_op2 = 0;
  logic [31:0] wr_data = 0;
  logic wr_err, rd_err, prot_enable;
  logic [31:0] rd_data, data_cacheable, insn_cacheable, wbuf_ctrl, data_perm_ext, insn_perm_ext;
  logic [NR*32-1:0] region_desc;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_cfg_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_prim(wr_prim), .wr_op2(wr_op2), .wr_crm(wr_crm),
    .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_prim(rd_prim), .rd_op2(rd_op2), .rd_crm(rd_crm),
    .rd_data(rd_data), .rd_err(rd_err),
    .prot_enable(prot_enable), .data_cacheable(data_cacheable),
    .insn_cacheable(insn_cacheable), .wbuf_ctrl(wbuf_ctrl),
    .data_perm_ext(data_perm_ext), .insn_perm_ext(insn_perm_ext),
    .region_desc(region_desc));

  function automatic logic [31:0] ref_spread(input logic [31:0] c);
    logic [31:0] r = 0;
    for (int i = 0; i < 8; i++) r |= ((c >> (2*i)) & 32'h3) << (4*i);
    return r;
  endfunction

  function automatic logic [31:0] ref_gather(input logic [31:0] x);
    logic [31:0] r = 0;
    for (int i = 0; i < 8; i++) r |= ((x >> (4*i)) & 32'h3) << (2*i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [2:0] o, input logic [3:0] c,
                    input logic [31:0] d, input logic exp_err, input string req);
    @(negedge clk);
    wr_en = 1; wr_prim = p; wr_op2 = o; wr_crm = c; wr_data = d;
    #1 chk(req, 256'(wr_err), 256'(exp_err));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [3:0] p, input logic [2:0] o, input logic [3:0] c,
                        input logic [31:0] exp_d, input logic exp_err, input string req);
    @(negedge clk);
    rd_en = 1; rd_prim = p; rd_op2 = o; rd_crm = c;
    #1;
    chk(req, 256'(rd_err), 256'(exp_err));
    chk(req, 256'(rd_data), 256'(exp_d));
    rd_en = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 prot_enable", 256'(prot_enable), 0);
    chk("R1 perms", {data_perm_ext, insn_perm_ext}, 0);
    chk("R1 regions", region_desc, 0);
    chk("R1 cache/wbuf", {data_cacheable, insn_cacheable, wbuf_ctrl}, 0);
    rd_chk(4'd1, 3'd0, 4'd0, 32'h0, 1'b0, "R1 ctrl read");
  endtask

  task automatic t_ident();
    rd_chk(4'd0, 3'd0, 4'd0, 32'h4105_9461, 1'b0, "R2 id");
    rd_chk(4'd0, 3'd1, 4'd3, 32'h0F00_4006, 1'b0, "R2 cache type");
    rd_chk(4'd0, 3'd2, 4'd0, 32'h0, 1'b1, "R2 op2=2 read");
    wr(4'd0, 3'd0, 4'd0, 32'h1234_5678, 1'b1, "R2 write refused");
    rd_chk(4'd0, 3'd0, 4'd0, 32'h4105_9461, 1'b0, "R2 id after write");
  endtask

  task automatic t_control();
    // R12: value not visible before the write edge, read in same cycle sees old value
    @(negedge clk);
    wr_en = 1; wr_prim = 4'd1; wr_op2 = 3'd0; wr_crm = 4'd0; wr_data = 32'h0000_0005;
    rd_en = 1; rd_prim = 4'd1; rd_op2 = 3'd0; rd_crm = 4'd0;
    #1;
    chk("R12 old read", 256'(rd_data), 0);
    chk("R12 enable not yet", 256'(prot_enable), 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R12 new read", 256'(rd_data), 256'(32'h5));
    chk("R3 enable set", 256'(prot_enable), 1);
    rd_en = 0;
    wr(4'd1, 3'd0, 4'd0, 32'hFFFF_FFFE, 1'b0, "R3 write");
    chk("R3 enable clear", 256'(prot_enable), 0);
    rd_chk(4'd1, 3'd0, 4'd0, 32'hFFFF_FFFE, 1'b0, "R3 readback");
    wr(4'd1, 3'd1, 4'd0, 32'h1, 1'b1, "R3 op2=1 refused");
    chk("R11 enable unchanged", 256'(prot_enable), 0);
  endtask

  task automatic t_cache();
    wr(4'd2, 3'd0, 4'd0, 32'h0000_00A5, 1'b0, "R4 data");
    wr(4'd2, 3'd1, 4'd0, 32'h0000_005A, 1'b0, "R4 insn");
    chk("R4 outputs", {data_cacheable, insn_cacheable}, {32'hA5, 32'h5A});
    rd_chk(4'd2, 3'd0, 4'd0, 32'hA5, 1'b0, "R4 data read");
    rd_chk(4'd2, 3'd1, 4'd0, 32'h5A, 1'b0, "R4 insn read");
    wr(4'd2, 3'd2, 4'd0, 32'hFFFF, 1'b1, "R4 op2=2 write");
    rd_chk(4'd2, 3'd7, 4'd0, 32'h0, 1'b1, "R4 op2=7 read");
    chk("R11 cache unchanged", {data_cacheable, insn_cacheable}, {32'hA5, 32'h5A});
  endtask

  task automatic t_wbuf();
    wr(4'd3, 3'd5, 4'd7, 32'hC0FF_EE00, 1'b0, "R5 write odd op2/crm");
    chk("R5 output", 256'(wbuf_ctrl), 256'(32'hC0FF_EE00));
    rd_chk(4'd3, 3'd0, 4'd0, 32'hC0FF_EE00, 1'b0, "R5 read");
  endtask

  task automatic t_compact();
    wr(4'd5, 3'd0, 4'd0, 32'hFFFF_A5C3, 1'b0, "R6 data compact");
    chk("R6 data ext", 256'(data_perm_ext), 256'(ref_spread(32'h0000_A5C3)));
    rd_chk(4'd5, 3'd0, 4'd0, 32'h0000_A5C3, 1'b0, "R7 data compact read");
    wr(4'd5, 3'd1, 4'd0, 32'h0000_1234, 1'b0, "R6 insn compact");
    rd_chk(4'd5, 3'd3, 4'd0, ref_spread(32'h1234), 1'b0, "R6 insn ext view");
    rd_chk(4'd5, 3'd1, 4'd0, 32'h0000_1234, 1'b0, "R7 insn compact read");
    chk("R6 data untouched", 256'(data_perm_ext), 256'(ref_spread(32'hA5C3)));
  endtask

  task automatic t_ext();
    wr(4'd5, 3'd2, 4'd0, 32'hDEAD_BEEF, 1'b0, "R8 data ext");
    rd_chk(4'd5, 3'd2, 4'd0, 32'hDEAD_BEEF, 1'b0, "R8 data ext read");
    rd_chk(4'd5, 3'd0, 4'd0, ref_gather(32'hDEAD_BEEF), 1'b0, "R7 gather of ext");
    wr(4'd5, 3'd3, 4'd0, 32'h7654_3210, 1'b0, "R8 insn ext");
    chk("R8 insn out", 256'(insn_perm_ext), 256'(32'h7654_3210));
    wr(4'd5, 3'd4, 4'd0, 32'h0, 1'b1, "R8 op2=4 write");
    rd_chk(4'd5, 3'd6, 4'd0, 32'h0, 1'b1, "R8 op2=6 read");
    chk("R11 perms unchanged", {data_perm_ext, insn_perm_ext}, {32'hDEAD_BEEF, 32'h7654_3210});
  endtask

  task automatic t_region();
    logic [NR*32-1:0] exp_flat = '0;
    for (int n = 0; n < NR; n++) begin
      logic [31:0] v = 32'h1000_0001 + 32'(n) * 32'h0101_0110;
      wr(4'd6, 3'(n), 4'(n), v, 1'b0, "R9 region write");
      exp_flat[n*32 +: 32] = v;
    end
    chk("R9 region outputs", region_desc, exp_flat);
    for (int n = 0; n < NR; n++)
      rd_chk(4'd6, 3'd0, 4'(n), exp_flat[n*32 +: 32], 1'b0, "R9 region read");
    wr(4'd6, 3'd0, 4'd8, 32'hFFFF_FFFF, 1'b1, "R9 crm=8 write");
    rd_chk(4'd6, 3'd0, 4'd15, 32'h0, 1'b1, "R9 crm=15 read");
    chk("R11 regions unchanged", region_desc, exp_flat);
  endtask

  task automatic t_undef();
    logic [3:0] bad [6] = '{4'd4, 4'd7, 4'd9, 4'd11, 4'd12, 4'd15};
    for (int k = 0; k < 6; k++) begin
      wr(bad[k], 3'd0, 4'd1, 32'hFFFF_FFFF, 1'b1, "R10 write");
      rd_chk(bad[k], 3'd0, 4'd1, 32'h0, 1'b1, "R10 read");
    end
    rd_chk(4'd1, 3'd0, 4'd0, 32'hFFFF_FFFE, 1'b0, "R11 ctrl kept");
    rd_chk(4'd3, 3'd0, 4'd0, 32'hC0FF_EE00, 1'b0, "R11 wbuf kept");
    chk("R11 enable kept", 256'(prot_enable), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ident();
    t_control();
    t_cache();
    t_wbuf();
    t_compact();
    t_ext();
    t_region();
    t_undef();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule